// File: doc/BRIEF.md
# Ethernet Transmit Framer

This block converts a frame body handed over by a host, one byte at a time, into a serial transmit stream of one NRZ bit per clock. The host writes the destination address, source address, length/type field and payload through a valid/ready byte port. It marks the final byte of each frame with a flag. The bytes are held in an internal buffer.

Transmission begins once two conditions hold. The first is that the buffer holds enough bytes: a selectable byte count, or a complete frame. The second is that a medium-access grant input is high. The framer then sends the preamble and the start-of-frame delimiter, followed by the body. When padding is enabled, it pads short bodies with zero bytes up to the legal minimum. Unless inhibited, it closes the frame with a CRC-32 check sequence.

If the host falls behind after a frame has started, the frame is cut off and a one-cycle status pulse is raised. The framer then discards the rest of that frame as the host delivers it.

Top module: `eth_tx_framer`

## Requirements
- R1: A frame on the line starts with seven bytes of 0x55 followed by the delimiter byte 0xD5. Every byte is sent least-significant bit first, one bit per clock. `tx_en` is high from the first preamble bit through the final bit of the frame and low otherwise.
- R2: The body bytes follow the delimiter in the order the host wrote them, with no gap and nothing inserted.
- R3: With `crc_inhibit` low, four check bytes follow the body and pad. They are the IEEE 802.3 CRC-32: polynomial 0x04C11DB7, register preset to all ones, result complemented, computed over body and pad. The 32 bits are sent with the complemented CRC's bit 0 first.
- R4: With `crc_inhibit` high, the frame ends after the last body or pad bit and no check bytes are sent.
- R5: With `pad_en` high and a body shorter than 60 bytes, zero bytes are appended until body plus pad is 60 bytes (64 with the check sequence). The pad is covered by the CRC.
- R6: With `pad_en` low, no pad is added whatever the body length. A body of 60 bytes or more never receives pad.
- R7: `start_sel` chooses how many bytes must be buffered before a start: 0 = 5 bytes, 1 = 381 bytes, 2 = 1021 bytes, 3 = a complete frame. No frame starts while fewer bytes than the selected count are buffered and no complete frame is buffered.
- R8: A completely buffered frame (its last-flagged byte written) is allowed to start under any `start_sel` setting, even when it is shorter than the selected count.
- R9: While `grant` is low no frame starts and no buffered byte is consumed. The whole frame is sent intact once `grant` rises. A start happens only in the cycle after `grant` was seen high.
- R10: When the buffer runs empty in the middle of a body, `tx_en` falls after the last bit of the current byte. `underrun` is high for exactly that one cycle. The remaining bytes of that frame, up to and including its last-flagged byte, are dropped without being sent.
- R11: While `rst_n` is low at a clock edge, the framer returns to idle and empties its buffer. `tx_en` and `underrun` are then low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 8 | Frame body byte from the host |
| in_last | input | 1 | Marks the final body byte of a frame |
| in_valid | input | 1 | Host byte is valid |
| in_ready | output | 1 | Buffer can accept a byte |
| start_sel | input | 2 | Start threshold select (see R7) |
| pad_en | input | 1 | Enable padding of short bodies |
| crc_inhibit | input | 1 | Suppress the check sequence |
| grant | input | 1 | Medium access permitted |
| tx_bit | output | 1 | Serial NRZ transmit bit |
| tx_en | output | 1 | Transmit enable, high during a frame |
| underrun | output | 1 | One-cycle pulse on a frame aborted for lack of data |

## Verification
Every internal state of the framer shows at the ports within one byte time, because the serializer puts out its state bit by bit. A wrong preamble count or a wrong bit index corrupts the frame inside its first 64 bits. A wrong body-length counter changes the number of pad bytes, and therefore the frame length, by a multiple of 8 bits. A damaged CRC register shows only in the final 32 bits.

A miscounted buffer level moves the cycle in which `tx_en` first rises. A flush that ends too early or too late shows up either as an unexpected frame made of leftover bytes or as a following frame that goes missing.

// File: rtl/txf_pkg.sv
// Shared constants and types for the transmit framer.
// Assumes an 8-bit host byte path and the reflected CRC-32 form.
package txf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_BODY,
        ST_PAD,
        ST_FCS,
        ST_FLUSH
    } txf_state_e;

    localparam logic [7:0]  PREAMBLE_BYTE = 8'h55;
    localparam logic [7:0]  SFD_BYTE      = 8'hD5;
    localparam int          PREAMBLE_LEN  = 7;
    localparam int          MIN_BODY      = 60;
    localparam logic [31:0] CRC_POLY_REV  = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;

    localparam int THR_SEL0 = 5;
    localparam int THR_SEL1 = 381;
    localparam int THR_SEL2 = 1021;

endpackage

// File: rtl/txf_fifo.sv
// Byte buffer between host and serializer. First-word fall-through:
// rd_data shows the oldest entry while not empty. Assumes the caller
// never pops when empty; pushes when full are refused by the caller.
module txf_fifo #(
    parameter int WIDTH = 9,
    parameter int AW    = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [AW:0]      count,
    output logic             full,
    output logic             empty
);
    localparam int DEPTH = 1 << AW;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;

    // storage write, no reset on the array
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wptr] <= wr_data;
        end
    end

    // pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_en) begin
                wptr <= wptr + 1'b1;
            end
            if (rd_en) begin
                rptr <= rptr + 1'b1;
            end
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // flags and fall-through read port
    always_comb begin
        full    = (count == (AW+1)'(DEPTH));
        empty   = (count == '0);
        rd_data = mem[rptr];
    end

endmodule

// File: rtl/txf_arm.sv
// Start-arming logic: tracks how many complete frames sit in the
// buffer and compares the fill level against the selected threshold.
// Assumes push/pop strobes are the same ones driving the buffer.
module txf_arm
    import txf_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  logic        push_last,
    input  logic        pop,
    input  logic        pop_last,
    input  logic [AW:0] level,
    input  logic [1:0]  sel,
    output logic        armed
);
    localparam logic [AW:0] T0 = (AW+1)'(THR_SEL0);
    localparam logic [AW:0] T1 = (AW+1)'(THR_SEL1);
    localparam logic [AW:0] T2 = (AW+1)'(THR_SEL2);

    logic [AW:0] frames;
    logic        inc;
    logic        dec;
    logic        level_ok;

    assign inc = push && push_last;
    assign dec = pop && pop_last;

    // count of last-flagged bytes waiting in the buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frames <= '0;
        end else if (inc && !dec) begin
            frames <= frames + 1'b1;
        end else if (dec && !inc) begin
            frames <= frames - 1'b1;
        end
    end

    // threshold decode and arming decision
    always_comb begin
        case (sel)
            2'd0:    level_ok = (level >= T0);
            2'd1:    level_ok = (level >= T1);
            2'd2:    level_ok = (level >= T2);
            default: level_ok = 1'b0;
        endcase
        armed = level_ok || (frames != '0);
    end

endmodule

// File: rtl/txf_crc.sv
// Bit-serial CRC-32 in reflected form: one line bit per enabled cycle.
// Assumes bits arrive in transmit order (LSB of each byte first).
module txf_crc
    import txf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic        bit_in,
    output logic [31:0] crc
);
    logic fb;

    assign fb = crc[0] ^ bit_in;

    // preset on frame start, shift on each covered bit
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            crc <= CRC_PRESET;
        end else if (en) begin
            crc <= (crc >> 1) ^ (fb ? CRC_POLY_REV : 32'h0);
        end
    end

endmodule

// File: rtl/txf_ctrl.sv
// Frame sequencer and serializer. Walks preamble, delimiter, body, pad
// and check sequence, one bit per clock. Assumes the buffer is non-empty
// when a start is requested (guaranteed by the arming logic).
module txf_ctrl
    import txf_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_req,
    input  logic        pad_en,
    input  logic        crc_inhibit,
    input  logic [7:0]  fifo_data,
    input  logic        fifo_last,
    input  logic        fifo_empty,
    input  logic [31:0] crc_val,
    output logic        pop,
    output logic        crc_init,
    output logic        crc_en,
    output logic        crc_bit,
    output logic        tx_bit,
    output logic        tx_en,
    output logic        underrun
);
    localparam logic [CW-1:0] MIN_CNT = CW'(MIN_BODY);
    localparam logic [2:0]    PRE_SFD = 3'(PREAMBLE_LEN - 1);
    localparam logic [2:0]    PRE_END = 3'(PREAMBLE_LEN);

    txf_state_e    state;
    logic [7:0]    byte_reg;
    logic [2:0]    bit_idx;
    logic [2:0]    pre_cnt;
    logic [CW-1:0] body_cnt;
    logic [4:0]    fcs_idx;
    logic          cur_last;
    logic          pad_l;
    logic          inh_l;
    logic          byte_end;
    logic          start;
    logic [CW-1:0] pad_next;

    assign byte_end = (bit_idx == 3'd7);
    assign start    = (state == ST_IDLE) && start_req;
    assign pad_next = body_cnt + 1'b1;

    // buffer pop strobe for each state that consumes host bytes
    always_comb begin
        case (state)
            ST_PRE:   pop = byte_end && (pre_cnt == PRE_END);
            ST_BODY:  pop = byte_end && !cur_last && !fifo_empty;
            ST_FLUSH: pop = !fifo_empty;
            default:  pop = 1'b0;
        endcase
    end

    // line outputs and CRC feed
    always_comb begin
        crc_init = start;
        crc_en   = (state == ST_BODY) || (state == ST_PAD);
        crc_bit  = byte_reg[bit_idx];
        tx_en    = (state == ST_PRE) || (state == ST_BODY) ||
                   (state == ST_PAD) || (state == ST_FCS);
        tx_bit   = (state == ST_FCS) ? ~crc_val[fcs_idx] : byte_reg[bit_idx];
    end

    // sequencer state, shift position and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            byte_reg <= '0;
            bit_idx  <= '0;
            pre_cnt  <= '0;
            body_cnt <= '0;
            fcs_idx  <= '0;
            cur_last <= 1'b0;
            pad_l    <= 1'b0;
            inh_l    <= 1'b0;
            underrun <= 1'b0;
        end else begin
            underrun <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_PRE;
                        byte_reg <= PREAMBLE_BYTE;
                        bit_idx  <= '0;
                        pre_cnt  <= '0;
                        pad_l    <= pad_en;
                        inh_l    <= crc_inhibit;
                    end
                end
                ST_PRE: begin
                    bit_idx <= bit_idx + 1'b1;
                    if (byte_end) begin
                        pre_cnt <= pre_cnt + 1'b1;
                        if (pre_cnt == PRE_SFD) begin
                            byte_reg <= SFD_BYTE;
                        end else if (pre_cnt == PRE_END) begin
                            state    <= ST_BODY;
                            byte_reg <= fifo_data;
                            cur_last <= fifo_last;
                            body_cnt <= CW'(1);
                        end
                    end
                end
                ST_BODY: begin
                    bit_idx <= bit_idx + 1'b1;
                    if (byte_end) begin
                        if (cur_last) begin
                            if (pad_l && (body_cnt < MIN_CNT)) begin
                                state    <= ST_PAD;
                                byte_reg <= 8'h00;
                            end else if (!inh_l) begin
                                state   <= ST_FCS;
                                fcs_idx <= '0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (fifo_empty) begin
                            state    <= ST_FLUSH;
                            underrun <= 1'b1;
                        end else begin
                            byte_reg <= fifo_data;
                            cur_last <= fifo_last;
                            body_cnt <= body_cnt + 1'b1;
                        end
                    end
                end
                ST_PAD: begin
                    bit_idx <= bit_idx + 1'b1;
                    if (byte_end) begin
                        body_cnt <= pad_next;
                        if (pad_next >= MIN_CNT) begin
                            if (!inh_l) begin
                                state   <= ST_FCS;
                                fcs_idx <= '0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                end
                ST_FCS: begin
                    fcs_idx <= fcs_idx + 1'b1;
                    if (fcs_idx == 5'd31) begin
                        state <= ST_IDLE;
                    end
                end
                ST_FLUSH: begin
                    if (pop && fifo_last) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/eth_tx_framer.sv
// Ethernet transmit framer top: host byte port into a buffer, arming
// on a fill threshold or complete frame plus grant, then serial output
// with preamble, delimiter, optional pad and optional CRC-32.
// Assumes one line bit per clock and a host faster than the line.
module eth_tx_framer #(
    parameter int AW = 11,
    parameter int CW = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [1:0] start_sel,
    input  logic       pad_en,
    input  logic       crc_inhibit,
    input  logic       grant,
    output logic       tx_bit,
    output logic       tx_en,
    output logic       underrun
);
    logic        push;
    logic        pop;
    logic [8:0]  rd_word;
    logic [AW:0] level;
    logic        full;
    logic        empty;
    logic        armed;
    logic        crc_init;
    logic        crc_en;
    logic        crc_bit;
    logic [31:0] crc_val;

    assign in_ready = !full;
    assign push     = in_valid && !full;

    txf_fifo #(.WIDTH(9), .AW(AW)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push),
        .wr_data ({in_last, in_data}),
        .rd_en   (pop),
        .rd_data (rd_word),
        .count   (level),
        .full    (full),
        .empty   (empty)
    );

    txf_arm #(.AW(AW)) u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_last (in_last),
        .pop       (pop),
        .pop_last  (rd_word[8]),
        .level     (level),
        .sel       (start_sel),
        .armed     (armed)
    );

    txf_crc u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (crc_init),
        .en     (crc_en),
        .bit_in (crc_bit),
        .crc    (crc_val)
    );

    txf_ctrl #(.CW(CW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (armed && grant),
        .pad_en      (pad_en),
        .crc_inhibit (crc_inhibit),
        .fifo_data   (rd_word[7:0]),
        .fifo_last   (rd_word[8]),
        .fifo_empty  (empty),
        .crc_val     (crc_val),
        .pop         (pop),
        .crc_init    (crc_init),
        .crc_en      (crc_en),
        .crc_bit     (crc_bit),
        .tx_bit      (tx_bit),
        .tx_en       (tx_en),
        .underrun    (underrun)
    );

endmodule

// File: rtl/eth_tx_framer_chk.sv
// Port-level protocol checks for the transmit framer, bound to the top.
module eth_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic grant,
    input logic tx_en,
    input logic tx_bit,
    input logic underrun
);
    logic [15:0] run_len;

    // length of the current tx_en run in bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (tx_en) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R1
    first_bit_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> tx_bit);

    // R1
    whole_octets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> (run_len[2:0] == 3'd0));

    // R9
    start_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(grant));

    // R10
    underrun_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);

    // R10
    underrun_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (!tx_en && $past(tx_en)));

endmodule

bind eth_tx_framer eth_tx_framer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (grant),
    .tx_en    (tx_en),
    .tx_bit   (tx_bit),
    .underrun (underrun)
);

// File: tb/eth_tx_framer_test.sv
module eth_tx_framer_test;

    localparam int HALF = 10;
    localparam int NVEC = 7;
    // {len[10:0], sel[1:0], pad, inhibit}
    localparam logic [14:0] VEC [NVEC] = '{
        {11'd64, 2'd3, 1'b1, 1'b0},
        {11'd14, 2'd3, 1'b1, 1'b0},
        {11'd14, 2'd3, 1'b0, 1'b0},
        {11'd59, 2'd0, 1'b1, 1'b0},
        {11'd60, 2'd1, 1'b1, 1'b0},
        {11'd20, 2'd2, 1'b1, 1'b1},
        {11'd30, 2'd3, 1'b0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] start_sel = 2'd3;
    logic       pad_en = 1'b0;
    logic       crc_inhibit = 1'b0;
    logic       grant = 1'b0;
    logic       tx_bit;
    logic       tx_en;
    logic       underrun;

    logic [7:0]  body [0:2047];
    logic        exp_bits [0:16383];
    logic        cap [0:65535];
    int          exp_len;
    int          cap_total = 0;
    int          und_total = 0;
    int          base;
    int          und_base;
    int          checks = 0;
    int          fails = 0;
    logic [31:0] bcrc;

    always #(HALF) clk = ~clk;

    eth_tx_framer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_data     (in_data),
        .in_last     (in_last),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .start_sel   (start_sel),
        .pad_en      (pad_en),
        .crc_inhibit (crc_inhibit),
        .grant       (grant),
        .tx_bit      (tx_bit),
        .tx_en       (tx_en),
        .underrun    (underrun)
    );

    // line monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && tx_en) begin
            cap[cap_total] = tx_bit;
            cap_total = cap_total + 1;
        end
        if (rst_n && underrun) begin
            und_total = und_total + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r = c;
        for (int k = 0; k < 8; k++) begin
            if (r[0] ^ b[k]) r = (r >> 1) ^ 32'hEDB88320;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic add_byte(input logic [7:0] b, input bit covered);
        for (int k = 0; k < 8; k++) begin
            exp_bits[exp_len] = b[k];
            exp_len++;
        end
        if (covered) bcrc = crc_byte(bcrc, b);
    endtask

    task automatic build_exp(input int n, input bit pad, input bit inh);
        logic [31:0] fcs;
        exp_len = 0;
        bcrc = 32'hFFFFFFFF;
        for (int i = 0; i < 7; i++) add_byte(8'h55, 1'b0);
        add_byte(8'hD5, 1'b0);
        for (int i = 0; i < n; i++) add_byte(body[i], 1'b1);
        if (pad) begin
            for (int i = n; i < 60; i++) add_byte(8'h00, 1'b1);
        end
        if (!inh) begin
            fcs = ~bcrc;
            for (int k = 0; k < 32; k++) begin
                exp_bits[exp_len] = fcs[k];
                exp_len++;
            end
        end
    endtask

    task automatic fill_body(input int n, input int seed);
        for (int i = 0; i < n; i++) body[i] = 8'((i * 37) + (seed * 11) + 3);
    endtask

    task automatic push_range(input int lo, input int hi, input int last_at);
        for (int i = lo; i < hi; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = body[i];
            in_last  = (i == last_at);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_frame();
        while (!tx_en) @(negedge clk);
        while (tx_en) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cmp_frame(input string req);
        int bad = -1;
        chk(cap_total - base == exp_len, req, cap_total - base, exp_len);
        for (int i = 0; i < exp_len; i++) begin
            if (bad < 0 && cap[base + i] !== exp_bits[i]) bad = i;
        end
        chk(bad < 0, {req, " first mismatching bit index"}, bad, -1);
    endtask

    task automatic thr_test(input logic [1:0] sel, input int thr, input int total);
        fill_body(total, int'(sel) + 20);
        start_sel = sel; pad_en = 1'b0; crc_inhibit = 1'b0; grant = 1'b1;
        base = cap_total;
        push_range(0, thr - 1, -1);
        idle(40);
        // R7: one byte short of the threshold, no frame starts
        chk(cap_total == base, "R7 early start", cap_total - base, 0);
        push_range(thr - 1, total, total - 1);
        wait_frame();
        build_exp(total, 1'b0, 1'b0);
        cmp_frame("R7 threshold frame");
        grant = 1'b0;
    endtask

    // watchdog
    initial begin
        #(HALF * 2 * 150000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(tx_en == 1'b0, "R11 tx_en after reset", int'(tx_en), 0);
        chk(underrun == 1'b0, "R11 underrun after reset", int'(underrun), 0);
        chk(in_ready == 1'b1, "R11 in_ready after reset", int'(in_ready), 1);

        // table walk: R1 R2 R3 R4 R5 R6 R8 R9
        for (int v = 0; v < NVEC; v++) begin
            int n = int'(VEC[v][14:4]);
            fill_body(n, v);
            start_sel   = VEC[v][3:2];
            pad_en      = VEC[v][1];
            crc_inhibit = VEC[v][0];
            grant       = 1'b0;
            base = cap_total;
            push_range(0, n, n - 1);
            idle(20);
            // R9: grant low holds the frame back
            chk(cap_total == base, "R9 start without grant", cap_total - base, 0);
            grant = 1'b1;
            wait_frame();
            grant = 1'b0;
            build_exp(n, VEC[v][1], VEC[v][0]);
            // R1 R2 R3 R4 R5 R6 R8 whole-frame compare
            cmp_frame($sformatf("R1/R2/R3/R4/R5/R6/R8 vector %0d", v));
        end

        // R7 thresholds 381 and 1021
        thr_test(2'd1, 381, 400);
        thr_test(2'd2, 1021, 1100);

        // R10: underrun after six bytes
        fill_body(16, 40);
        start_sel = 2'd0; pad_en = 1'b0; crc_inhibit = 1'b1; grant = 1'b1;
        base = cap_total;
        und_base = und_total;
        push_range(0, 6, -1);
        idle(200);
        chk(und_total - und_base == 1, "R10 underrun pulse count", und_total - und_base, 1);
        build_exp(6, 1'b0, 1'b1);
        cmp_frame("R10 truncated frame");
        push_range(6, 16, 15);
        idle(40);
        chk(cap_total - base == 112, "R10 remainder dropped", cap_total - base, 112);
        chk(und_total - und_base == 1, "R10 no second pulse", und_total - und_base, 1);

        // R10: next frame is clean after the flush
        fill_body(14, 50);
        start_sel = 2'd3; pad_en = 1'b1; crc_inhibit = 1'b0;
        base = cap_total;
        push_range(0, 14, 13);
        wait_frame();
        build_exp(14, 1'b1, 1'b0);
        cmp_frame("R10 frame after flush");

        // R11: reset in mid frame
        fill_body(14, 60);
        push_range(0, 14, 13);
        idle(100);
        rst_n = 1'b0;
        @(negedge clk);
        chk(tx_en == 1'b0, "R11 tx_en in reset", int'(tx_en), 0);
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R11 in_ready after mid reset", int'(in_ready), 1);
        base = cap_total;
        idle(100);
        chk(cap_total == base, "R11 buffer emptied", cap_total - base, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule